// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block collects event strobes from eleven source groups and folds them into one top-level summary register. Each group has its own set of 32-bit registers. An event strobe is latched into a group's pending register when its mask bit is clear. The group's pending bits, gated by its enable register, are then reduced onto one or two bits of the summary register. The summary register also holds one writable bit, the global enable. When that enable is set and any summary bit is set, the controller emits a one-cycle interrupt pulse each time it re-evaluates.

Software reaches every register through a plain 32-bit read/write port with a 12-bit byte address. The summary register is at 0x000. Group `g` (0 to 10) has its base at 0x040 + 0x10*g, with four words: live event view at +0x0, mask at +0x4, pending at +0x8 and enable at +0xC. The groups map to summary bits as follows:

| Group | Pending bits used | Summary bit |
|---|---|---|
| 0 | low half / high half | 0 / 1 |
| 1 | low half / high half | 2 / 3 |
| 2 | low half only | 4 |
| 3 | low half only | 6 |
| 4, 5, 6 | all | 16, 17, 18 |
| 7 | all | 20 |
| 8 | all | 22 |
| 9 | all | 23 |
| 10 | all | 30 |

Bit 31 of the summary register is the global enable.

Top module: `irq_tree_ctrl`

## Requirements
- R1: Reset (`rst` high at a clock edge) clears every mask, pending, enable and global-enable bit, and it clears `rdata`. In the cycle after reset, `irq_pulse` is low.
- R2: An event bit sets the matching pending bit only if the group's mask bit is 0. A masked event is discarded. Clearing the mask later does not bring it back.
- R3: Writing a group's pending word (+0x8) clears exactly the bits written as 1. All other pending bits keep their value.
- R4: A read returns its data on `rdata` one cycle after `rd_en`. Mask, pending and enable read back at +0x4, +0x8 and +0xC. The +0x0 word returns the group's event strobes as they are in the read cycle. Any unmapped or unaligned address reads 0.
- R5: A summary bit is 1 exactly when its group has at least one bit set in (pending AND enable) within that bit's selected bits, following the routing table above. Pending bits in the high half of groups 2 and 3 never reach the summary.
- R6: Summary bits 30..0 are read-only. A write to 0x000 changes only bit 31, the global enable. Reading 0x000 returns {global enable, summary bits 30..0}.
- R7: The controller re-evaluates in the cycle after one of these: a write to any mask or enable word or to 0x000, or any event bit high in any group, masked or not. If at that re-evaluation the global enable is 1 and a summary bit is set, `irq_pulse` is high for that one cycle. A write to a pending word is not a trigger, and `irq_pulse` is never high without a re-evaluation.
- R8: If an event and a clear of the same pending bit arrive in the same cycle, the bit ends set. If an event arrives in the same cycle as a mask write, the event is filtered by the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| evt | input | 352 | Event strobes; group g occupies bits [32g+31:32g] |
| irq_pulse | output | 1 | One-cycle interrupt pulse toward the host |

## Verification
The hardest situations to reach from the ports are the ones where two register effects land in the same cycle:
- an event and a clear of the same pending bit;
- an event and a mask write.

In both cases the result depends on ordering inside one clock edge. The bench drives write strobes and event strobes together in a single cycle and then reads the pending word back to see which side won.

Two other cases are also hard to see from outside:
- the pulse caused by a masked event, which changes no state but still triggers a re-evaluation;
- the silent pending clear, which changes state but must not trigger one.

A scripted walk reaches both, with the global enable set so that a pulse would be visible.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int DW         = 32;
    localparam int AW         = 12;
    localparam int N_GROUPS   = 11;
    localparam int N_ROUTES   = 13;
    localparam int GIDX_W     = $clog2(N_GROUPS);
    localparam int GEN_BIT    = DW - 1;
    localparam int SUM_W      = DW - 1;
    localparam int MBIT_W     = $clog2(DW);
    localparam int STRIDE_LOG = 4;

    localparam logic [AW-1:0] MASTER_ADDR = AW'(12'h000);
    localparam logic [AW-1:0] GRP_BASE    = AW'(12'h040);
    localparam logic [AW-1:0] GRP_SPAN    = AW'(N_GROUPS << STRIDE_LOG);

    typedef logic [N_GROUPS-1:0][DW-1:0] grp_vec_t;

    typedef enum logic [1:0] {
        FLD_LIVE  = 2'd0,
        FLD_MASK  = 2'd1,
        FLD_PEND  = 2'd2,
        FLD_ENA   = 2'd3
    } grp_fld_e;

    typedef struct packed {
        logic [GIDX_W-1:0] grp;
        logic [MBIT_W-1:0] mbit;
        logic [DW-1:0]     sel;
    } route_t;

    localparam logic [DW-1:0] SEL_LO  = 32'h0000_FFFF;
    localparam logic [DW-1:0] SEL_HI  = 32'hFFFF_0000;
    localparam logic [DW-1:0] SEL_ALL = 32'hFFFF_FFFF;

    function automatic route_t mk_route(input int g, input int b, input logic [DW-1:0] s);
        route_t e;
        e.grp  = GIDX_W'(g);
        e.mbit = MBIT_W'(b);
        e.sel  = s;
        return e;
    endfunction

    function automatic route_t route_at(input int idx);
        case (idx)
            0:       return mk_route(0, 0, SEL_LO);
            1:       return mk_route(0, 1, SEL_HI);
            2:       return mk_route(1, 2, SEL_LO);
            3:       return mk_route(1, 3, SEL_HI);
            4:       return mk_route(2, 4, SEL_LO);
            5:       return mk_route(3, 6, SEL_LO);
            6:       return mk_route(4, 16, SEL_ALL);
            7:       return mk_route(5, 17, SEL_ALL);
            8:       return mk_route(6, 18, SEL_ALL);
            9:       return mk_route(7, 20, SEL_ALL);
            10:      return mk_route(8, 22, SEL_ALL);
            11:      return mk_route(9, 23, SEL_ALL);
            default: return mk_route(10, 30, SEL_ALL);
        endcase
    endfunction

endpackage

// File: rtl/irq_grp_regs.sv
module irq_grp_regs
    import irqagg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] evt,
    input  logic [DW-1:0] wdata,
    input  logic          we_mask,
    input  logic          we_pend,
    input  logic          we_ena,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] pend_q,
    output logic [DW-1:0] ena_q
);
    logic [DW-1:0] clr_bits;
    logic [DW-1:0] set_bits;
    logic [DW-1:0] pend_n;

    always_comb begin
        clr_bits = we_pend ? wdata : '0;
        set_bits = evt & ~mask_q;
        pend_n   = (pend_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pend_q <= '0;
            ena_q  <= '0;
        end else begin
            pend_q <= pend_n;
            if (we_mask) mask_q <= wdata;
            if (we_ena)  ena_q  <= wdata;
        end
    end
endmodule

// File: rtl/irq_route.sv
module irq_route
    import irqagg_pkg::*;
(
    input  grp_vec_t         active,
    output logic [SUM_W-1:0] summary
);
    route_t ent;

    always_comb begin
        summary = '0;
        ent     = '0;
        for (int r = 0; r < N_ROUTES; r++) begin
            ent = route_at(r);
            if (|(active[ent.grp] & ent.sel))
                summary[ent.mbit] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_master.sv
module irq_master
    import irqagg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             wbit,
    input  logic             trig,
    input  logic [SUM_W-1:0] summary,
    output logic             gen_q,
    output logic             irq_o
);
    logic reeval_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q    <= 1'b0;
            reeval_q <= 1'b0;
        end else begin
            if (we) gen_q <= wbit;
            reeval_q <= trig;
        end
    end

    assign irq_o = reeval_q & gen_q & (|summary);
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
    import irqagg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    output logic [DW-1:0]          rdata,
    input  logic [N_GROUPS*DW-1:0] evt,
    output logic                   irq_pulse
);
    grp_vec_t            evt_v;
    grp_vec_t            active;
    logic [DW-1:0]       mask_q [N_GROUPS];
    logic [DW-1:0]       pend_q [N_GROUPS];
    logic [DW-1:0]       ena_q  [N_GROUPS];
    logic [N_GROUPS-1:0] we_mask, we_pend, we_ena;
    logic [AW-1:0]       off;
    logic                in_grp, is_master;
    logic [GIDX_W-1:0]   gidx;
    grp_fld_e            fld;
    logic [SUM_W-1:0]    summary;
    logic                gen_q;
    logic                master_we, trig;
    logic [DW-1:0]       rd_val;

    assign evt_v     = grp_vec_t'(evt);
    assign off       = addr - GRP_BASE;
    assign in_grp    = (addr >= GRP_BASE) && (off < GRP_SPAN) && (off[1:0] == 2'b00);
    assign gidx      = off[STRIDE_LOG +: GIDX_W];
    assign fld       = grp_fld_e'(off[3:2]);
    assign is_master = (addr == MASTER_ADDR);
    assign master_we = wr_en && is_master;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic hit;
        assign hit        = wr_en && in_grp && (gidx == GIDX_W'(g));
        assign we_mask[g] = hit && (fld == FLD_MASK);
        assign we_pend[g] = hit && (fld == FLD_PEND);
        assign we_ena[g]  = hit && (fld == FLD_ENA);

        irq_grp_regs u_regs (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt_v[g]),
            .wdata   (wdata),
            .we_mask (we_mask[g]),
            .we_pend (we_pend[g]),
            .we_ena  (we_ena[g]),
            .mask_q  (mask_q[g]),
            .pend_q  (pend_q[g]),
            .ena_q   (ena_q[g])
        );

        assign active[g] = pend_q[g] & ena_q[g];
    end

    irq_route u_route (
        .active  (active),
        .summary (summary)
    );

    assign trig = master_we || (|we_mask) || (|we_ena) || (|evt);

    irq_master u_master (
        .clk     (clk),
        .rst     (rst),
        .we      (master_we),
        .wbit    (wdata[GEN_BIT]),
        .trig    (trig),
        .summary (summary),
        .gen_q   (gen_q),
        .irq_o   (irq_pulse)
    );

    always_comb begin
        rd_val = '0;
        if (is_master) begin
            rd_val = {gen_q, summary};
        end else if (in_grp) begin
            case (fld)
                FLD_LIVE: rd_val = evt_v[gidx];
                FLD_MASK: rd_val = mask_q[gidx];
                FLD_PEND: rd_val = pend_q[gidx];
                default:  rd_val = ena_q[gidx];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end
endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk
    import irqagg_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [AW-1:0]          addr,
    input logic [N_GROUPS*DW-1:0] evt,
    input logic                   irq_pulse,
    input logic                   gen_en,
    input logic [SUM_W-1:0]       summary,
    input logic [DW-1:0]          pend0,
    input logic [DW-1:0]          mask0,
    input logic                   we_pend0
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !irq_pulse);

    a_r2_masked_drop: assert property (@(posedge clk) disable iff (rst)
        (pend0 & ~$past(pend0) & $past(mask0)) == '0);

    a_r3_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
        (|($past(pend0) & ~pend0)) |-> $past(we_pend0));

    a_r6_gen_only_by_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(gen_en) |-> $past(wr_en && addr == MASTER_ADDR));

    a_r7_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (gen_en && summary != '0));

    a_r7_irq_after_trigger: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(wr_en || (|evt)));
endmodule

bind irq_tree_ctrl irq_tree_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .evt       (evt),
    .irq_pulse (irq_pulse),
    .gen_en    (gen_q),
    .summary   (summary),
    .pend0     (pend_q[0]),
    .mask0     (mask_q[0]),
    .we_pend0  (we_pend[0])
);

// File: tb/irq_tree_ctrl_test.sv
module irq_tree_ctrl_test;
    import irqagg_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   wr_en = 1'b0;
    logic                   rd_en = 1'b0;
    logic [AW-1:0]          addr = '0;
    logic [DW-1:0]          wdata = '0;
    logic [DW-1:0]          rdata;
    logic [N_GROUPS*DW-1:0] evt = '0;
    logic                   irq_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    logic          seen_irq;
    logic [DW-1:0] seen_rd;

    always #5 clk = ~clk;

    irq_tree_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt(evt), .irq_pulse(irq_pulse)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_EV = 2'd1, OP_RD = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  grp;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{OP_WR, 4'd0,  12'h04C, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd7}, // R7 gen off
        '{OP_WR, 4'd0,  12'h000, 32'h8000_0000, 32'h0,         1'b0, 4'd7}, // R7 empty summary
        '{OP_EV, 4'd0,  12'h000, 32'h0000_0001, 32'h0,         1'b1, 4'd7}, // R7 event pulse
        '{OP_RD, 4'd0,  12'h000, 32'h0,         32'h8000_0001, 1'b0, 4'd5}, // R5 low half
        '{OP_EV, 4'd0,  12'h000, 32'h0001_0000, 32'h0,         1'b1, 4'd7},
        '{OP_RD, 4'd0,  12'h000, 32'h0,         32'h8000_0003, 1'b0, 4'd5}, // R5 high half
        '{OP_WR, 4'd0,  12'h048, 32'h0000_0001, 32'h0,         1'b0, 4'd7}, // R7 clear no pulse
        '{OP_RD, 4'd0,  12'h000, 32'h0,         32'h8000_0002, 1'b0, 4'd3}, // R3
        '{OP_RD, 4'd0,  12'h048, 32'h0,         32'h0001_0000, 1'b0, 4'd3}, // R3
        '{OP_WR, 4'd0,  12'h044, 32'h0000_0010, 32'h0,         1'b1, 4'd7}, // R7 mask write
        '{OP_EV, 4'd0,  12'h000, 32'h0000_0010, 32'h0,         1'b1, 4'd7}, // R7 masked event
        '{OP_RD, 4'd0,  12'h048, 32'h0,         32'h0001_0000, 1'b0, 4'd2}, // R2 dropped
        '{OP_WR, 4'd0,  12'h048, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd3},
        '{OP_RD, 4'd0,  12'h000, 32'h0,         32'h8000_0000, 1'b0, 4'd3},
        '{OP_EV, 4'd2,  12'h000, 32'h0001_0000, 32'h0,         1'b0, 4'd5}, // R5 not enabled
        '{OP_WR, 4'd0,  12'h06C, 32'hFFFF_FFFF, 32'h0,         1'b0, 4'd5}, // R5 high half ignored
        '{OP_RD, 4'd0,  12'h000, 32'h0,         32'h8000_0000, 1'b0, 4'd5},
        '{OP_EV, 4'd2,  12'h000, 32'h0000_0001, 32'h0,         1'b1, 4'd5},
        '{OP_RD, 4'd0,  12'h000, 32'h0,         32'h8000_0010, 1'b0, 4'd5}, // R5 bit 4
        '{OP_EV, 4'd10, 12'h000, 32'h0100_0000, 32'h0,         1'b1, 4'd7},
        '{OP_WR, 4'd0,  12'h0EC, 32'h0100_0000, 32'h0,         1'b1, 4'd7}, // R7 enable write
        '{OP_RD, 4'd0,  12'h000, 32'h0,         32'hC000_0010, 1'b0, 4'd5}, // R5 bit 30
        '{OP_WR, 4'd0,  12'h000, 32'h7FFF_FFFF, 32'h0,         1'b0, 4'd6}, // R6
        '{OP_RD, 4'd0,  12'h000, 32'h0,         32'h4000_0010, 1'b0, 4'd6}, // R6 summary kept
        '{OP_RD, 4'd0,  12'h004, 32'h0,         32'h0,         1'b0, 4'd4}  // R4 unmapped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic [11:0] a,
                       input logic [31:0] d, input int g, input logic [31:0] ev);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        evt = '0;
        evt[g*DW +: DW] = ev;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; evt = '0;
        seen_irq = irq_pulse;
        seen_rd  = rdata;
    endtask

    initial begin
        #(200000 * 10);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq after reset", {31'b0, irq_pulse}, 32'h0);
        check("R1 rdata after reset", rdata, 32'h0);
        cyc(0, 1, 12'h000, 0, 0, 0); check("R1 master", seen_rd, 32'h0);
        cyc(0, 1, 12'h044, 0, 0, 0); check("R1 mask", seen_rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            cyc(v.op == OP_WR, v.op == OP_RD, v.a, v.d, int'(v.grp),
                (v.op == OP_EV) ? v.d : 32'h0);
            n_tests++;
            if (seen_irq !== v.exp_irq) begin
                n_fail++;
                $display("FAIL R%0d vec %0d irq: actual %b expected %b", v.req, i, seen_irq, v.exp_irq);
            end
            if (v.op == OP_RD) begin
                n_tests++;
                if (seen_rd !== v.exp_rd) begin
                    n_fail++;
                    $display("FAIL R%0d vec %0d rdata: actual %h expected %h", v.req, i, seen_rd, v.exp_rd);
                end
            end
        end

        // R5 pipe group 4 routes to bit 16
        cyc(1, 0, 12'h08C, 32'h1, 0, 0);
        cyc(0, 0, 12'h000, 0, 4, 32'h1);
        cyc(0, 1, 12'h000, 0, 0, 0); check("R5 pipe bit16", seen_rd, 32'h4001_0010);

        // R8 event and clear of the same bit in one cycle: set wins
        cyc(1, 0, 12'h048, 32'h100, 0, 32'h100);
        cyc(0, 1, 12'h048, 0, 0, 0); check("R8 set wins", seen_rd, 32'h100);

        // R8 event with mask write: old mask filters
        cyc(1, 0, 12'h044, 32'h200, 0, 32'h200);
        cyc(0, 1, 12'h048, 0, 0, 0); check("R8 old mask", seen_rd, 32'h300);
        cyc(0, 1, 12'h044, 0, 0, 0); check("R4 mask readback", seen_rd, 32'h200);

        // R2 new mask now drops the event
        cyc(1, 0, 12'h048, 32'h200, 0, 0);
        cyc(0, 0, 12'h000, 0, 0, 32'h200);
        cyc(0, 1, 12'h048, 0, 0, 0); check("R2 masked drop", seen_rd, 32'h100);

        // R4 live view and enable readback
        cyc(0, 1, 12'h0B0, 0, 7, 32'h0000_A5A5); check("R4 live view", seen_rd, 32'h0000_A5A5);
        cyc(0, 1, 12'h0EC, 0, 0, 0); check("R4 enable readback", seen_rd, 32'h0100_0000);
        cyc(0, 1, 12'h100, 0, 0, 0); check("R4 beyond groups", seen_rd, 32'h0);

        // R7 pulse lasts one cycle
        cyc(1, 0, 12'h000, 32'h8000_0000, 0, 0); check("R7 gen on pulse", {31'b0, seen_irq}, 32'h1);
        cyc(0, 0, 12'h000, 0, 0, 0);             check("R7 idle no pulse", {31'b0, seen_irq}, 32'h0);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R1 irq low", {31'b0, irq_pulse}, 32'h0);
        cyc(0, 1, 12'h000, 0, 0, 0); check("R1 master cleared", seen_rd, 32'h0);
        cyc(0, 1, 12'h048, 0, 0, 0); check("R1 pending cleared", seen_rd, 32'h0);
        cyc(0, 1, 12'h0EC, 0, 0, 0); check("R1 enable cleared", seen_rd, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule